// File: doc/BRIEF.md
# Real-Time Clock with Staged Register Commit

This block is a real-time-clock peripheral on a simple 32-bit register bus. It holds a seconds counter that keeps running, an alarm compare value, six persistent configuration words and a control word. Software writes to the seconds, alarm and persistent registers do not take effect at once. Each such write lands in a pending copy and raises a per-register stale flag. A commit sequencer then moves pending copies into the live (committed) set one at a time, in a fixed priority order. Software polls the stale flags in the status word to learn when a write has landed.

The control word and the first persistent word each have set and clear aliases. A write of ones to an alias sets or clears only those bits, with no read-modify-write by software. An alarm fires when the committed seconds value equals the committed alarm value while the alarm-enable bit is committed. The interrupt output is the latched alarm status gated by its enable bit.

Top module: `rtc_staged`

## Requirements
- R1: After reset, control, status stale field, watchdog, all persistent and alarm values read 0, the stale flags are clear and `irq_alarm` is 0.
- R2: Control lives at 0x00, with a set alias at 0x04 and a clear alias at 0x08. Bits 0 (alarm IE), 1 (ms IE) and 4 (watchdog enable) follow a plain write at 0x00. At 0x04 and 0x08 only the bits written as 1 change. Bit 2 (alarm status) cannot be set by software and is cleared only through 0x08.
- R3: A write to a staged register sets its stale flag at status bit 16+index, with the effect visible on the next cycle. The indices are persistent0..5 = 0..5 (addresses 0x60, 0x70, 0x80, 0x90, 0xA0, 0xB0), alarm (0x40) = 6 and seconds (0x30) = 7.
- R4: Reads of staged registers return the committed value, never a pending one.
- R5: While any flag is stale, the sequencer commits the lowest-index stale register once every COMMIT_CYCLES clocks and clears its flag. A lone write to an idle block has its flag clear after exactly COMMIT_CYCLES clocks.
- R6: While committed persistent1 bit 31 is 1, one stale register is committed every clock.
- R7: Seconds increments once every TICK_DIV clocks. A commit to seconds loads the pending value in place of that cycle's increment.
- R8: When committed seconds equals committed alarm and persistent0 bit 2 (alarm enable) is committed as 1, control bit 2 is set on the next clock. `irq_alarm` equals control bit 2 AND control bit 0.
- R9: If a clear of control bit 2 arrives in a cycle where the alarm match holds, the bit stays set.
- R10: On a match while persistent0 bit 1 (wake enable) is 1, persistent0 bit 7 (wake flag) sets. Plain writes and set-alias writes never change bit 7. A clear-alias write with bit 7 = 1 clears it when persistent0 is next committed.
- R11: The persistent0 set alias (0x64) stages base OR data and the clear alias (0x68) stages base AND NOT data. The base is the pending value when persistent0 is stale and the committed value otherwise.
- R12: Status (0x10) always reads bit 31 as 1. Reads of the set/clear aliases return their base register. The watchdog register (0x50) is not staged and reads back the value written.
- R13: A write that hits a register in the same cycle as its commit lets the old pending value commit, leaves the flag set, and commits the new value on a later turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data is valid the cycle after |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_alarm | output | 1 | Alarm interrupt, registered |

## Verification
Two collisions are driven on purpose. In the first, a second write to the same register is issued on exactly the clock at which the first write's commit fires. The check is that the old value reads back, the flag stays raised, and the new value lands later. In the second, software clears the alarm status while seconds still equals alarm. The expected result is that the status bit and the interrupt stay high, and that a clear issued after seconds has moved on takes effect. A behavioural model in the bench follows every clock, so read data and the interrupt are also judged on each cycle of these sequences.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam int N_STAGED = 8;

  localparam logic [ADDR_W-1:0] A_CTRL     = 8'h00;
  localparam logic [ADDR_W-1:0] A_CTRL_SET = 8'h04;
  localparam logic [ADDR_W-1:0] A_CTRL_CLR = 8'h08;
  localparam logic [ADDR_W-1:0] A_STAT     = 8'h10;
  localparam logic [ADDR_W-1:0] A_SEC      = 8'h30;
  localparam logic [ADDR_W-1:0] A_ALM      = 8'h40;
  localparam logic [ADDR_W-1:0] A_WDOG     = 8'h50;
  localparam logic [ADDR_W-1:0] A_P0       = 8'h60;
  localparam logic [ADDR_W-1:0] A_P0_SET   = 8'h64;
  localparam logic [ADDR_W-1:0] A_P0_CLR   = 8'h68;
  localparam logic [ADDR_W-1:0] A_P1       = 8'h70;
  localparam logic [ADDR_W-1:0] A_P2       = 8'h80;
  localparam logic [ADDR_W-1:0] A_P3       = 8'h90;
  localparam logic [ADDR_W-1:0] A_P4       = 8'hA0;
  localparam logic [ADDR_W-1:0] A_P5       = 8'hB0;

  // commit priority order: lower index commits first
  localparam int IDX_P0  = 0;
  localparam int IDX_P1  = 1;
  localparam int IDX_ALM = 6;
  localparam int IDX_SEC = 7;

  localparam int CB_ALM_IE = 0;
  localparam int CB_MS_IE  = 1;
  localparam int CB_ALM_ST = 2;
  localparam int CB_WD_EN  = 4;

  localparam int PB_WAKE_EN = 1;
  localparam int PB_ALM_EN  = 2;
  localparam int PB_WAKE    = 7;
  localparam int PB_FORCE   = 31;

  localparam int STALE_LSB   = 16;
  localparam int PRESENT_BIT = 31;

  localparam logic [DATA_W-1:0] CTRL_SW_M =
    (DATA_W'(1) << CB_ALM_IE) | (DATA_W'(1) << CB_MS_IE) | (DATA_W'(1) << CB_WD_EN);
  localparam logic [DATA_W-1:0] CTRL_ALL_M = CTRL_SW_M | (DATA_W'(1) << CB_ALM_ST);
  localparam logic [DATA_W-1:0] WAKE_M     = DATA_W'(1) << PB_WAKE;
endpackage

// File: rtl/rtc_commit_seq.sv
module rtc_commit_seq #(
  parameter int N             = 8,
  parameter int COMMIT_CYCLES = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] stale,
  input  logic         fast,
  output logic [N-1:0] commit_oh
);
  localparam int CNT_W = (COMMIT_CYCLES > 1) ? $clog2(COMMIT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(COMMIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             any_stale;
  logic             fire;
  logic [N-1:0]     lowest;

  assign any_stale = |stale;
  // isolate the lowest set bit: highest priority pending register
  assign lowest    = stale & (~stale + N'(1));
  assign fire      = any_stale && (fast || (cnt_q == CNT_LAST));
  assign commit_oh = fire ? lowest : '0;

  always_ff @(posedge clk) begin
    if (rst || fire || !any_stale) cnt_q <= '0;
    else                           cnt_q <= cnt_q + CNT_W'(1);
  end

  AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (rst) $onehot0(commit_oh)); // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst) cnt_q <= CNT_LAST); // R5
  AST_FAST_COMMIT: assert property (@(posedge clk) disable iff (rst) (fast && any_stale) |-> (|commit_oh)); // R6
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
  parameter int W        = 32,
  parameter int TICK_DIV = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] sec
);
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [TW-1:0] T_LAST = TW'(TICK_DIV - 1);

  logic [TW-1:0] tick_q;
  logic          wrap;

  assign wrap = (tick_q == T_LAST);

  always_ff @(posedge clk) begin
    if (rst || wrap) tick_q <= '0;
    else             tick_q <= tick_q + TW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)       sec <= '0;
    else if (load) sec <= load_val;
    else if (wrap) sec <= sec + W'(1);
  end

  AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst) (wrap && !load) |=> (sec == $past(sec) + W'(1))); // R7
  AST_SEC_LOAD: assert property (@(posedge clk) disable iff (rst) load |=> (sec == $past(load_val))); // R7
endmodule

// File: rtl/rtc_staged.sv
module rtc_staged
  import rtc_pkg::*;
#(
  parameter int COMMIT_CYCLES = 8,
  parameter int TICK_DIV      = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_alarm
);
  logic [DATA_W-1:0]   ctrl_q, ctrl_d, wdog_q, sec_q, stat_word;
  logic [DATA_W-1:0]   pend_q [N_STAGED];
  logic [DATA_W-1:0]   keep_q [N_STAGED-1];
  logic [N_STAGED-1:0] stale_q, stale_d, wr_oh, commit_oh;
  logic [DATA_W-1:0]   p0_base, p0_wdata;
  logic ctrl_wr, ctrl_set_wr, ctrl_clr_wr, p0_set_wr, p0_clr_wr, wdog_wr;
  logic match, wake_set, wake_q, wclr_q, irq_q;

  // address decode
  always_comb begin
    wr_oh       = '0;
    ctrl_wr     = 1'b0;
    ctrl_set_wr = 1'b0;
    ctrl_clr_wr = 1'b0;
    p0_set_wr   = 1'b0;
    p0_clr_wr   = 1'b0;
    wdog_wr     = 1'b0;
    if (bus_wr) begin
      case (bus_addr)
        A_CTRL:     ctrl_wr     = 1'b1;
        A_CTRL_SET: ctrl_set_wr = 1'b1;
        A_CTRL_CLR: ctrl_clr_wr = 1'b1;
        A_WDOG:     wdog_wr     = 1'b1;
        A_P0:       wr_oh[IDX_P0] = 1'b1;
        A_P0_SET: begin wr_oh[IDX_P0] = 1'b1; p0_set_wr = 1'b1; end
        A_P0_CLR: begin wr_oh[IDX_P0] = 1'b1; p0_clr_wr = 1'b1; end
        A_P1:       wr_oh[IDX_P1]  = 1'b1;
        A_P2:       wr_oh[2]       = 1'b1;
        A_P3:       wr_oh[3]       = 1'b1;
        A_P4:       wr_oh[4]       = 1'b1;
        A_P5:       wr_oh[5]       = 1'b1;
        A_ALM:      wr_oh[IDX_ALM] = 1'b1;
        A_SEC:      wr_oh[IDX_SEC] = 1'b1;
        default: ;
      endcase
    end
  end

  // persistent0 alias merge; the wake flag is hardware-owned and never staged
  assign p0_base  = (stale_q[IDX_P0] ? pend_q[IDX_P0] : keep_q[IDX_P0]) & ~WAKE_M;
  assign p0_wdata = p0_set_wr ? ((p0_base | bus_wdata) & ~WAKE_M) :
                    p0_clr_wr ? (p0_base & ~bus_wdata) :
                                (bus_wdata & ~WAKE_M);

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_STAGED; i++) begin
      if (rst)           pend_q[i] <= '0;
      else if (wr_oh[i]) pend_q[i] <= (i == IDX_P0) ? p0_wdata : bus_wdata;
    end
  end

  assign stale_d = (stale_q & ~commit_oh) | wr_oh;

  always_ff @(posedge clk) begin
    if (rst) stale_q <= '0;
    else     stale_q <= stale_d;
  end

  rtc_commit_seq #(
    .N             (N_STAGED),
    .COMMIT_CYCLES (COMMIT_CYCLES)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .stale     (stale_q),
    .fast      (keep_q[IDX_P1][PB_FORCE]),
    .commit_oh (commit_oh)
  );

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_STAGED - 1; i++) begin
      if (rst)               keep_q[i] <= '0;
      else if (commit_oh[i]) keep_q[i] <= pend_q[i];
    end
  end

  rtc_seconds #(
    .W        (DATA_W),
    .TICK_DIV (TICK_DIV)
  ) u_sec (
    .clk      (clk),
    .rst      (rst),
    .load     (commit_oh[IDX_SEC]),
    .load_val (pend_q[IDX_SEC]),
    .sec      (sec_q)
  );

  // alarm compare on committed values only
  assign match    = (sec_q == keep_q[IDX_ALM]) && keep_q[IDX_P0][PB_ALM_EN];
  assign wake_set = match && keep_q[IDX_P0][PB_WAKE_EN];

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_q <= 1'b0;
      wclr_q <= 1'b0;
    end else begin
      wake_q <= (wake_q & ~(commit_oh[IDX_P0] & wclr_q)) | wake_set;
      if (p0_clr_wr && bus_wdata[PB_WAKE]) wclr_q <= 1'b1;
      else if (commit_oh[IDX_P0])          wclr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          wdog_q <= '0;
    else if (wdog_wr) wdog_q <= bus_wdata;
  end

  // control: hardware set of alarm status outranks a software clear
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr)     ctrl_d = (ctrl_q & ~CTRL_SW_M) | (bus_wdata & CTRL_SW_M);
    if (ctrl_set_wr) ctrl_d = ctrl_q | (bus_wdata & CTRL_SW_M);
    if (ctrl_clr_wr) ctrl_d = ctrl_q & ~(bus_wdata & CTRL_ALL_M);
    if (match)       ctrl_d[CB_ALM_ST] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      irq_q  <= ctrl_d[CB_ALM_ST] & ctrl_d[CB_ALM_IE];
    end
  end

  assign irq_alarm = irq_q;

  always_comb begin
    stat_word = '0;
    stat_word[STALE_LSB +: N_STAGED] = stale_q;
    stat_word[PRESENT_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        A_CTRL, A_CTRL_SET, A_CTRL_CLR: bus_rdata <= ctrl_q;
        A_STAT:                         bus_rdata <= stat_word;
        A_SEC:                          bus_rdata <= sec_q;
        A_ALM:                          bus_rdata <= keep_q[IDX_ALM];
        A_WDOG:                         bus_rdata <= wdog_q;
        A_P0, A_P0_SET, A_P0_CLR:       bus_rdata <= keep_q[IDX_P0] | (wake_q ? WAKE_M : '0);
        A_P1:                           bus_rdata <= keep_q[IDX_P1];
        A_P2:                           bus_rdata <= keep_q[2];
        A_P3:                           bus_rdata <= keep_q[3];
        A_P4:                           bus_rdata <= keep_q[4];
        A_P5:                           bus_rdata <= keep_q[5];
        default:                        bus_rdata <= '0;
      endcase
    end
  end

  AST_STALE_ON_WRITE: assert property (@(posedge clk) disable iff (rst) (|wr_oh) |=> ((stale_q & $past(wr_oh)) == $past(wr_oh))); // R3
  AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (rst) (|(commit_oh & ~wr_oh)) |=> ((stale_q & $past(commit_oh & ~wr_oh)) == '0)); // R5
  AST_ALARM_STATUS: assert property (@(posedge clk) disable iff (rst) match |=> ctrl_q[CB_ALM_ST]); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst) irq_alarm |-> (ctrl_q[CB_ALM_ST] && ctrl_q[CB_ALM_IE])); // R8
  AST_PRESENT: assert property (@(posedge clk) disable iff (rst) (bus_rd && bus_addr == A_STAT) |=> bus_rdata[PRESENT_BIT]); // R12
endmodule

// File: tb/rtc_staged_tb.sv
`timescale 1ns/1ps
module rtc_staged_tb;
  localparam int CC = 8;
  localparam int TD = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_staged #(.COMMIT_CYCLES(CC), .TICK_DIV(TD)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_alarm(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_comm [8];
  logic [31:0] m_pend [8];
  logic [7:0]  m_stale;
  int          m_cnt, m_tick;
  logic        m_wake, m_wclr, m_irq;
  logic [31:0] m_ctrl, m_wd, m_rdata;

  function automatic int stg_idx(logic [7:0] a);
    case (a)
      8'h60, 8'h64, 8'h68: return 0;
      8'h70: return 1;
      8'h80: return 2;
      8'h90: return 3;
      8'hA0: return 4;
      8'hB0: return 5;
      8'h40: return 6;
      8'h30: return 7;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] mread(logic [7:0] a);
    case (a)
      8'h00, 8'h04, 8'h08: return m_ctrl;
      8'h10: return {1'b1, 7'b0, m_stale, 16'h0};
      8'h30: return m_comm[7];
      8'h40: return m_comm[6];
      8'h50: return m_wd;
      8'h60, 8'h64, 8'h68: return m_comm[0] | {24'h0, m_wake, 7'h0};
      8'h70: return m_comm[1];
      8'h80: return m_comm[2];
      8'h90: return m_comm[3];
      8'hA0: return m_comm[4];
      8'hB0: return m_comm[5];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_stale = 0; m_cnt = 0; m_tick = 0; m_wake = 0; m_wclr = 0;
      m_irq = 0; m_ctrl = 0; m_wd = 0; m_rdata = 0;
      for (int i = 0; i < 8; i++) begin m_comm[i] = 0; m_pend[i] = 0; end
    end else begin
      logic [7:0]  old_stale;
      logic [31:0] base0, nv;
      logic        old_wclr, hit, wset;
      int          c_idx, w_idx;
      if (bus_rd) m_rdata = mread(bus_addr);
      old_stale = m_stale;
      old_wclr  = m_wclr;
      base0 = (old_stale[0] ? m_pend[0] : m_comm[0]) & ~32'h80;
      hit   = (m_comm[7] == m_comm[6]) && m_comm[0][2];
      wset  = hit && m_comm[0][1];
      c_idx = -1;
      if (old_stale != 0 && (m_comm[1][31] || m_cnt == CC - 1))
        for (int i = 7; i >= 0; i--) if (old_stale[i]) c_idx = i;
      if (c_idx >= 0) m_cnt = 0;
      else if (old_stale != 0) m_cnt++;
      else m_cnt = 0;
      m_wake = (m_wake && !(c_idx == 0 && old_wclr)) || wset;
      if (c_idx == 0) m_wclr = 0;
      if (c_idx == 7) m_comm[7] = m_pend[7];
      else if (m_tick == TD - 1) m_comm[7] = m_comm[7] + 1;
      m_tick = (m_tick == TD - 1) ? 0 : m_tick + 1;
      if (c_idx >= 0 && c_idx < 7) m_comm[c_idx] = m_pend[c_idx];
      if (c_idx >= 0) m_stale[c_idx] = 1'b0;
      if (bus_wr) begin
        case (bus_addr)
          8'h00: m_ctrl = (m_ctrl & ~32'h13) | (bus_wdata & 32'h13);
          8'h04: m_ctrl = m_ctrl | (bus_wdata & 32'h13);
          8'h08: m_ctrl = m_ctrl & ~(bus_wdata & 32'h17);
          8'h50: m_wd = bus_wdata;
          default: ;
        endcase
        w_idx = stg_idx(bus_addr);
        if (w_idx >= 0) begin
          nv = bus_wdata;
          if (w_idx == 0) begin
            if (bus_addr == 8'h64) nv = (base0 | bus_wdata) & ~32'h80;
            else if (bus_addr == 8'h68) begin
              nv = base0 & ~bus_wdata;
              if (bus_wdata[7]) m_wclr = 1;
            end else nv = bus_wdata & ~32'h80;
          end
          m_pend[w_idx] = nv;
          m_stale[w_idx] = 1'b1;
        end
      end
      if (hit) m_ctrl[2] = 1'b1;
      m_irq = m_ctrl[2] & m_ctrl[0];
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      chk("R4 per-cycle read data", bus_rdata, m_rdata);
      chk("R8 per-cycle irq", {31'h0, irq}, {31'h0, m_irq});
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_clear();
    logic [31:0] v;
    for (int k = 0; k < 200; k++) begin
      rd(8'h10, v);
      if (v[23:16] == 8'h0) break;
    end
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL R5 watchdog expired: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    int n;
    logic [7:0] seen [4];
    int ns;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    running = 1'b1;

    // R1 reset state
    rd(8'h00, v);  chk("R1 ctrl after reset", v, 32'h0);
    rd(8'h10, v);  chk("R1 status after reset", v, 32'h8000_0000);
    rd(8'h60, v);  chk("R1 persistent0 after reset", v, 32'h0);
    rd(8'h50, v);  chk("R1 watchdog after reset", v, 32'h0);
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);

    // R2 control and its aliases
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); chk("R2 plain write mask", v, 32'h13);
    wr(8'h08, 32'h2);         rd(8'h00, v); chk("R2 clear alias", v, 32'h11);
    wr(8'h04, 32'h4);         rd(8'h00, v); chk("R2 status not settable", v, 32'h11);
    wr(8'h04, 32'h2);         rd(8'h00, v); chk("R2 set alias", v, 32'h13);
    rd(8'h04, v); chk("R12 set alias reads base", v, 32'h13);
    rd(8'h08, v); chk("R12 clear alias reads base", v, 32'h13);

    // R12 watchdog register is immediate
    wr(8'h50, 32'h1234); rd(8'h50, v); chk("R12 watchdog readback", v, 32'h1234);

    // R3 / R4 staging of alarm
    wr(8'h40, 32'd1000);
    rd(8'h10, v); chk("R3 alarm stale flag", v, 32'h8040_0000);
    rd(8'h40, v); chk("R4 alarm reads committed", v, 32'h0);
    wait_clear();
    rd(8'h40, v); chk("R5 alarm committed", v, 32'd1000);

    // R5 exact commit latency
    wr(8'h80, 32'h55);
    n = 0;
    for (int k = 0; k < 100; k++) begin
      rd(8'h10, v);
      if (v[18]) n++; else break;
    end
    chk("R5 commit latency", 32'(n), 32'(CC));

    // R3 / R5 commit order
    wr(8'h30, 32'd500); wr(8'h40, 32'd9999); wr(8'h70, 32'h0);
    rd(8'h10, v); chk("R3 three stale flags", v, 32'h80C2_0000);
    ns = 0;
    v2 = v;
    for (int k = 0; k < 200 && ns < 4; k++) begin
      rd(8'h10, v);
      if (v[23:16] != v2[23:16]) begin seen[ns] = v[23:16]; ns++; end
      v2 = v;
      if (v[23:16] == 0) break;
    end
    chk("R5 order step count", 32'(ns), 32'd3);
    chk("R5 order first", {24'h0, seen[0]}, 32'hC0);
    chk("R5 order second", {24'h0, seen[1]}, 32'h80);
    chk("R5 order third", {24'h0, seen[2]}, 32'h00);

    // R7 tick rate
    rd(8'h30, v);
    idle(TD - 1);
    rd(8'h30, v2);
    chk("R7 one tick per TICK_DIV", v2 - v, 32'd1);
    wr(8'h30, 32'd7); wait_clear();
    rd(8'h30, v);
    chk("R7 seconds load overrides", 32'(v == 32'd7 || v == 32'd8), 32'd1);

    // R6 fast commit mode
    wr(8'h70, 32'h8000_0000); wait_clear();
    wr(8'h90, 32'h33);
    rd(8'h10, v); chk("R6 flag after write", v, 32'h8008_0000);
    rd(8'h10, v); chk("R6 flag clear next cycle", v, 32'h8000_0000);
    rd(8'h90, v); chk("R6 value committed", v, 32'h33);
    wr(8'h70, 32'h0); wait_clear();

    // R13 write on the commit edge
    wr(8'h80, 32'hAAAA);
    idle(CC - 1);
    wr(8'h80, 32'hBBBB);
    rd(8'h80, v); chk("R13 old value committed", v, 32'hAAAA);
    rd(8'h10, v); chk("R13 flag stays set", v, 32'h8004_0000);
    wait_clear();
    rd(8'h80, v); chk("R13 new value committed", v, 32'hBBBB);

    // R11 persistent0 alias merge on pending base
    wr(8'h60, 32'h04); wr(8'h64, 32'h02);
    wait_clear();
    rd(8'h60, v); chk("R11 set alias on pending", v, 32'h06);

    // R8 / R9 / R10 alarm
    wr(8'h30, 32'd300); wr(8'h40, 32'd302); wait_clear();
    for (int k = 0; k < 6 * TD && !irq; k++) idle(1);
    chk("R8 irq on match", {31'h0, irq}, 32'h1);
    rd(8'h00, v); chk("R8 status bit set", v, 32'h17);
    wr(8'h08, 32'h4);
    rd(8'h00, v); chk("R9 clear during match loses", v, 32'h17);
    chk("R9 irq held", {31'h0, irq}, 32'h1);
    rd(8'h60, v); chk("R10 wake flag set", v, 32'h86);
    idle(TD + 2);
    wr(8'h08, 32'h4);
    rd(8'h00, v); chk("R8 status cleared", v, 32'h13);
    chk("R8 irq cleared", {31'h0, irq}, 32'h0);
    wr(8'h60, 32'h06); wait_clear();
    rd(8'h60, v); chk("R10 plain write keeps wake", v, 32'h86);
    wr(8'h68, 32'h80); wait_clear();
    rd(8'h60, v); chk("R10 clear alias clears wake", v, 32'h06);

    // R8 irq gated by enable
    wr(8'h08, 32'h1);
    rd(8'h30, v);
    wr(8'h40, v + 32'd3); wait_clear();
    for (int k = 0; k < 8 * TD; k++) begin
      rd(8'h00, v2);
      if (v2[2]) break;
    end
    chk("R8 status set with IE off", {31'h0, v2[2]}, 32'h1);
    chk("R8 irq stays low with IE off", {31'h0, irq}, 32'h0);

    idle(4);
    running = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule